// File: doc/BRIEF.md
# Receiver Power-Control Line Sequencer

This block steps eight receiver control lines through a timed power-up. A start pulse moves it out of idle into four warm-up states, one after another. Each warm-up state drives its own 8-bit line pattern for a programmed number of 625 µs steps. After the fourth warm-up state, the block enters a receiver-on state. It stays there until a stop pulse returns it to idle with all lines low. Any state can be marked so that the low-battery input is captured at the moment the state is left. Each capture raises a one-cycle strobe and updates a status bit that the host can read.

The host configures the block with packets. Each packet is presented as an ID byte plus a data word in a single cycle. The IDs are as follows:

| ID | Purpose |
|----|---------|
| 16h to 19h | Configure warm-up states 0 to 3 |
| 1Ah | Configure one of three receiver-on settings, chosen by a 4-bit setting code |
| 0Fh | Per-line override: a force bit and a value bit for each line |

The `rx_mode` input selects which receiver-on setting is used. Writes to a state's settings are applied only when that state is next entered. While reset is asserted, the line outputs are disabled, meaning they are high impedance at the pad.

Top module: `rx_line_sequencer`

## Requirements
- R1: While `rst_n` is low, `lines_oe`, `lines_o`, `state_o`, `bat_strobe` and `bat_status` are all 0. Packets presented during reset, including force packets, are not stored.
- R2: Once reset is released, `lines_oe` is 1 from the first clock onward. In idle (`state_o`=0), `lines_o` is 0 unless forced.
- R3: A `start` pulse in idle moves `state_o` through 1, 2, 3, 4 (warm-up states of IDs 16h, 17h, 18h, 19h) and then to 5 (receiver-on). Each warm-up state lasts ST×TICK_DIV clock cycles, where ST is the 7-bit step time in bits [14:8] of the warm-up packet. An ST of 0 counts as 1.
- R4: In warm-up state k, `lines_o[i]` equals bit i of that state's pattern, which is carried in bits [7:0] of packet 16h+k.
- R5: Packet 1Ah carries the pattern in bits [7:0], the battery flag in bit 15 and the setting code in bits [19:16]. Code 0111 stores bank 0 (1600 sps sync), 1000 stores bank 1 (3200 sps data) and 1001 stores bank 2 (1600 sps data). Any other code is ignored. On entry to state 5, `rx_mode` 0, 1 or 2 selects bank 0, 1 or 2, and `rx_mode` 3 selects bank 0.
- R6: When a state whose battery flag is set is left, whether by timeout or by stop, `bat_strobe` is 1 for the following cycle only. `bat_status` then holds the value `lobat_in` had at that exit edge. Leaving a state whose flag is clear changes neither output. The warm-up flag is bit 15 of the packet.
- R7: A `stop` pulse in any active state returns the block to idle at the next edge. `start` pulses in non-idle states are ignored.
- R8: A packet written while a state is active does not change that state's lines or duration. It is applied at the next entry to the state.
- R9: In packet 0Fh, bit 2i is the force bit and bit 2i+1 is the value bit of line i. While the force bit is set, line i shows the value bit in every state. When the force bit is cleared, line i returns to the sequenced value.
- R10: Without any configuration after reset, every warm-up step time is 1, so each warm-up state lasts TICK_DIV cycles with all lines low.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pkt_valid | input | 1 | Packet present this cycle |
| pkt_id | input | 8 | Packet ID byte |
| pkt_data | input | 20 | Packet payload |
| start | input | 1 | Launch the warm-up sequence |
| stop | input | 1 | Return to idle |
| rx_mode | input | 2 | Receiver-on bank select, sampled at entry |
| lobat_in | input | 1 | Low-battery port |
| lines_o | output | 8 | Receiver control line values |
| lines_oe | output | 1 | Drive enable for the control lines |
| bat_strobe | output | 1 | One-cycle pulse per battery capture |
| bat_status | output | 1 | Last captured battery state |
| state_o | output | 3 | 0 idle, 1 to 4 warm-up, 5 receiver-on |

## Verification
The bench first runs the sequence from reset defaults, which shows that every state lasts one step and keeps the lines low. It then runs with four distinct step times, including a zero code, four distinct patterns and alternating battery flags. This run separates the states from one another and checks that each exit captures the battery level at the right edge, while `lobat_in` keeps toggling. Further runs stop the sequence mid-warm-up, rewrite a state while it is active, and switch receiver-on banks after an ignored setting code. A per-line force is applied across a run and then cleared part-way through, which shows the override taking effect and then releasing the lines.

// File: rtl/rx_line_sequencer.sv
module rx_line_sequencer #(
  parameter int TICK_DIV = 20000
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        pkt_valid,
  input  logic [7:0]  pkt_id,
  input  logic [19:0] pkt_data,
  input  logic        start,
  input  logic        stop,
  input  logic [1:0]  rx_mode,
  input  logic        lobat_in,
  output logic [7:0]  lines_o,
  output logic        lines_oe,
  output logic        bat_strobe,
  output logic        bat_status,
  output logic [2:0]  state_o
);
  localparam int PW = (TICK_DIV > 1) ? $clog2(TICK_DIV) : 1;
  localparam logic [PW-1:0] PRE_LAST = PW'(TICK_DIV - 1);
  localparam logic [2:0] S_IDLE = 3'd0, S_WU3 = 3'd4, S_ON = 3'd5;

  logic [7:0]  wu_cls [4];
  logic [6:0]  wu_st  [4];
  logic [3:0]  wu_lbc;
  logic [7:0]  on_cls [3];
  logic [2:0]  on_lbc;
  logic [7:0]  frs, fval;

  logic [2:0]    state_q, nxt;
  logic [PW-1:0] pre_q;
  logic [6:0]    cnt_q;
  logic [7:0]    cls_act;
  logic          lbc_act, oe_q, leaving, tick, in_wu;
  logic [7:0]    wu_off;
  logic [1:0]    wk, bank;

  assign wu_off = pkt_id - 8'h16;
  assign tick   = (pre_q == PRE_LAST);
  assign in_wu  = (state_q != S_IDLE) && (state_q <= S_WU3);
  assign wk     = 2'(nxt - 3'd1);
  assign bank   = (rx_mode == 2'd3) ? 2'd0 : rx_mode;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int k = 0; k < 4; k++) begin
        wu_cls[k] <= '0;
        wu_st[k]  <= 7'd1;
      end
      for (int k = 0; k < 3; k++) on_cls[k] <= '0;
      wu_lbc <= '0;
      on_lbc <= '0;
      frs    <= '0;
      fval   <= '0;
    end else if (pkt_valid) begin
      if (pkt_id == 8'h0F) begin
        for (int i = 0; i < 8; i++) begin
          frs[i]  <= pkt_data[2*i];
          fval[i] <= pkt_data[2*i+1];
        end
      end else if (wu_off < 8'd4) begin
        wu_cls[wu_off[1:0]] <= pkt_data[7:0];
        wu_st[wu_off[1:0]]  <= pkt_data[14:8];
        wu_lbc[wu_off[1:0]] <= pkt_data[15];
      end else if (pkt_id == 8'h1A) begin
        case (pkt_data[19:16])
          4'b0111: begin on_cls[0] <= pkt_data[7:0]; on_lbc[0] <= pkt_data[15]; end
          4'b1000: begin on_cls[1] <= pkt_data[7:0]; on_lbc[1] <= pkt_data[15]; end
          4'b1001: begin on_cls[2] <= pkt_data[7:0]; on_lbc[2] <= pkt_data[15]; end
          default: ;
        endcase
      end
    end
  end

  always_comb begin
    nxt     = state_q;
    leaving = 1'b0;
    if (stop && state_q != S_IDLE) begin
      nxt     = S_IDLE;
      leaving = 1'b1;
    end else if (state_q == S_IDLE && start) begin
      nxt = 3'd1;
    end else if (in_wu && tick && cnt_q == 7'd1) begin
      nxt     = state_q + 3'd1;
      leaving = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= S_IDLE;
      pre_q      <= '0;
      cnt_q      <= '0;
      cls_act    <= '0;
      lbc_act    <= 1'b0;
      oe_q       <= 1'b0;
      bat_strobe <= 1'b0;
      bat_status <= 1'b0;
    end else begin
      oe_q       <= 1'b1;
      state_q    <= nxt;
      bat_strobe <= leaving && lbc_act;
      if (leaving && lbc_act) bat_status <= lobat_in;
      if (nxt != state_q) begin
        pre_q <= '0;
        if (nxt == S_IDLE) begin
          cls_act <= '0;
          lbc_act <= 1'b0;
          cnt_q   <= '0;
        end else if (nxt == S_ON) begin
          cls_act <= on_cls[bank];
          lbc_act <= on_lbc[bank];
          cnt_q   <= '0;
        end else begin
          cls_act <= wu_cls[wk];
          lbc_act <= wu_lbc[wk];
          cnt_q   <= (wu_st[wk] == 7'd0) ? 7'd1 : wu_st[wk];
        end
      end else begin
        pre_q <= tick ? '0 : pre_q + 1'b1;
        if (in_wu && tick) cnt_q <= cnt_q - 7'd1;
      end
    end
  end

  assign lines_oe = oe_q;
  assign lines_o  = oe_q ? ((frs & fval) | (~frs & cls_act)) : 8'h00;
  assign state_o  = state_q;

  // R3
  seq_order_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(state_q) != S_IDLE && $past(state_q) <= S_WU3 && state_q != $past(state_q))
    |-> (state_q == $past(state_q) + 3'd1 || state_q == S_IDLE));
  // R3
  cnt_nonzero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    in_wu |-> cnt_q != 7'd0);
  // R6
  strobe_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bat_strobe |-> ($past(lbc_act) && state_q != $past(state_q)));
  // R7
  stop_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ($past(stop) && $past(state_q) != S_IDLE) |-> state_q == S_IDLE);
  // R8
  hold_cfg_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == $past(state_q)) |-> (cls_act == $past(cls_act)));
endmodule

// File: tb/rx_line_sequencer_tb_top.sv
module rx_line_sequencer_tb_top;
  localparam int D = 4;
  logic clk = 0, rst_n = 0, pkt_valid = 0, start = 0, stop = 0, lobat_in = 0;
  logic [7:0] pkt_id = 0;
  logic [19:0] pkt_data = 0;
  logic [1:0] rx_mode = 0;
  logic [7:0] lines_o;
  logic lines_oe, bat_strobe, bat_status;
  logic [2:0] state_o;

  rx_line_sequencer #(.TICK_DIV(D)) dut_i (.*);

  always #5 clk = ~clk;

  typedef struct packed { logic [2:0] st; logic [7:0] ln; logic [15:0] len; } seg_t;
  seg_t seg_q[$];
  logic [2:0] bat_q[$];
  int checks = 0, fails = 0, cyc = 0;
  logic [7:0] frs_m = 0, fval_m = 0;
  logic done = 0;

  task automatic chk(input logic ok, input string what, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", what, act, exp);
    end
  endtask

  // Monitor: pops expected segments and battery captures
  logic [2:0] cur = 0, prev = 0;
  logic [7:0] exp_ln = 0, bad_ln = 0, bad_exp = 0;
  logic [15:0] exp_len = 0, len = 0;
  logic bad = 0;
  always @(negedge clk) begin
    if (rst_n) begin
      if (bat_strobe) begin
        if (bat_q.size() == 0) chk(0, "R6 unexpected battery strobe", prev, 0);
        else begin
          logic [2:0] s;
          s = bat_q.pop_front();
          chk(prev == s, "R6 strobe on exit of state", prev, s);
          chk(bat_status == lobat_in, "R6 captured battery level", bat_status, lobat_in);
        end
      end
      if (state_o != cur) begin
        chk(!bad, "R4/R5/R9 line pattern", bad_ln, bad_exp);
        if (cur != 0 && exp_len != 0) chk(len == exp_len, "R3 state duration", len, exp_len);
        if (state_o == 0) begin
          exp_ln = 0; exp_len = 0;
        end else if (seg_q.size() == 0) begin
          chk(0, "R3 unexpected state entry", state_o, 0);
        end else begin
          seg_t e;
          e = seg_q.pop_front();
          chk(state_o == e.st, "R3 state order", state_o, e.st);
          exp_ln = e.ln; exp_len = e.len;
        end
        len = 0; bad = 0; cur = state_o;
      end
      len++;
      if (!bad && lines_o !== ((frs_m & fval_m) | (~frs_m & exp_ln))) begin
        bad = 1; bad_ln = lines_o; bad_exp = (frs_m & fval_m) | (~frs_m & exp_ln);
      end
      prev = state_o;
      cyc++;
      lobat_in = cyc[1] ^ cyc[3];
    end
  end

  task automatic send(input logic [7:0] id, input logic [19:0] d);
    @(posedge clk); #2;
    pkt_valid = 1; pkt_id = id; pkt_data = d;
    @(posedge clk); #2;
    pkt_valid = 0;
    if (id == 8'h0F)
      for (int i = 0; i < 8; i++) begin
        frs_m[i] = d[2*i]; fval_m[i] = d[2*i+1];
      end
  endtask

  task automatic pulse(input logic is_stop);
    @(posedge clk); #2;
    if (is_stop) stop = 1; else start = 1;
    @(posedge clk); #2;
    stop = 0; start = 0;
  endtask

  task automatic wait_state(input logic [2:0] s);
    while (state_o != s) @(posedge clk);
  endtask

  function automatic seg_t mk(input logic [2:0] s, input logic [7:0] l, input int n);
    return {s, l, 16'(n)};
  endfunction

  function automatic logic [19:0] wu(input logic lbc, input logic [6:0] st, input logic [7:0] c);
    return {4'd0, lbc, st, c};
  endfunction

  initial begin
    // R1: reset holds outputs off and ignores a force packet
    pkt_valid = 1; pkt_id = 8'h0F; pkt_data = 20'h0FFFF;
    repeat (3) @(negedge clk);
    chk(lines_oe == 0, "R1 oe in reset", lines_oe, 0);
    chk(lines_o == 0, "R1 lines in reset", lines_o, 0);
    chk(state_o == 0, "R1 state in reset", state_o, 0);
    chk(bat_strobe == 0 && bat_status == 0, "R1 battery outputs in reset", {bat_strobe, bat_status}, 0);
    pkt_valid = 0;
    @(posedge clk); #2 rst_n = 1;
    repeat (3) @(negedge clk);
    // R2: enabled and idle-low; force packet from reset was not stored (R1)
    chk(lines_oe == 1, "R2 oe after reset", lines_oe, 1);
    chk(lines_o == 0, "R2 idle lines", lines_o, 0);

    // R10: defaults, each warm-up lasts one step
    for (int k = 1; k <= 4; k++) seg_q.push_back(mk(3'(k), 8'h00, D));
    seg_q.push_back(mk(3'd5, 8'h00, 0));
    pulse(0);
    wait_state(3'd5);
    repeat (3) @(posedge clk);
    pulse(1);
    repeat (4) @(posedge clk);

    // R3 R4 R5 R6: programmed run, rx_mode 1
    send(8'h16, wu(1, 7'd3, 8'hA1));
    send(8'h17, wu(0, 7'd0, 8'h5C));
    send(8'h18, wu(1, 7'd2, 8'h0F));
    send(8'h19, wu(0, 7'd5, 8'hF0));
    send(8'h1A, {4'b1000, 1'b1, 7'd0, 8'h3C});
    send(8'h1A, {4'b0111, 1'b0, 7'd0, 8'h11});
    send(8'h1A, {4'b1001, 1'b0, 7'd0, 8'h99});
    rx_mode = 2'd1;
    seg_q.push_back(mk(3'd1, 8'hA1, 3*D));
    seg_q.push_back(mk(3'd2, 8'h5C, D));
    seg_q.push_back(mk(3'd3, 8'h0F, 2*D));
    seg_q.push_back(mk(3'd4, 8'hF0, 5*D));
    seg_q.push_back(mk(3'd5, 8'h3C, 0));
    bat_q.push_back(3'd1); bat_q.push_back(3'd3); bat_q.push_back(3'd5);
    pulse(0);
    wait_state(3'd2);
    pulse(0); // R7: start while active is ignored
    wait_state(3'd4);
    send(8'h19, wu(0, 7'd5, 8'h77)); // R8: not applied to the active state
    wait_state(3'd5);
    repeat (5) @(posedge clk);
    pulse(1);
    repeat (4) @(posedge clk);

    // R7: stop during warm-up, R6 capture on stop
    seg_q.push_back(mk(3'd1, 8'hA1, 3*D));
    seg_q.push_back(mk(3'd2, 8'h5C, D));
    seg_q.push_back(mk(3'd3, 8'h0F, 0));
    bat_q.push_back(3'd1); bat_q.push_back(3'd3);
    pulse(0);
    wait_state(3'd3);
    @(posedge clk);
    pulse(1);
    @(negedge clk);
    chk(state_o == 0, "R7 stop to idle", state_o, 0);
    repeat (3) @(posedge clk);

    // R9: force lower four lines to 0101
    send(8'h0F, 20'h00077);
    @(negedge clk);
    chk(lines_o == 8'h05, "R9 forced idle lines", lines_o, 8'h05);
    // R5: ignored setting code, rx_mode 2 bank; R8 new WU3 pattern now applies
    send(8'h1A, {4'b0000, 1'b1, 7'd0, 8'hFF});
    rx_mode = 2'd2;
    seg_q.push_back(mk(3'd1, 8'hA1, 3*D));
    seg_q.push_back(mk(3'd2, 8'h5C, D));
    seg_q.push_back(mk(3'd3, 8'h0F, 2*D));
    seg_q.push_back(mk(3'd4, 8'h77, 5*D));
    seg_q.push_back(mk(3'd5, 8'h99, 0));
    bat_q.push_back(3'd1); bat_q.push_back(3'd3);
    pulse(0);
    wait_state(3'd4);
    send(8'h0F, 20'h00000); // R9: release override mid-state
    wait_state(3'd5);
    repeat (4) @(posedge clk);
    pulse(1);
    repeat (4) @(posedge clk);

    chk(seg_q.size() == 0, "R3 all expected states seen", seg_q.size(), 0);
    chk(bat_q.size() == 0, "R6 all expected captures seen", bat_q.size(), 0);
    if (!done) begin
      done = 1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      done = 1;
      checks++; fails++;
      $display("FAIL watchdog expired actual=0 expected=1");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end
endmodule